// File: doc/BRIEF.md
# Trap Entry Sequencer

This block performs the entry step of a 32-bit processor's trap mechanism. In every cycle it looks at a pending synchronous exception and a pending hardware interrupt request and picks one, or neither. On the next rising clock edge it registers the state the core needs in order to start the handler. That state is the saved status word, the saved program counter and the saved stack pointer, plus the event code for the trap. The new status word and the handler address come out with it.

The core presents the current status word, program counter, general register 15, vector base, a delay-slot flag and a sleep flag. The external interrupt controller receives the current acceptance level, taken from status bits [7:4]. It answers with a vector, and a vector of all ones means that nothing is accepted.

The status word uses four fixed fields: BL at bit 28, RB at bit 29, MD at bit 30, and the interrupt mask at bits [7:4].

Top module: `trap_entry_seq`

## Requirements
- R1: When an exception and an interrupt are both pending in the same cycle, the exception is taken. The interrupt-event output stays unchanged and the handler address is the exception handler's address.
- R2: When status bit 28 (BL) is set, any exception code other than 0x1E0 is recorded as code 0x000 and handled as a reset. Code 0x1E0 keeps its value and goes to vector base + 0x100.
- R3: `irqLevel` always equals status bits [7:4]. No interrupt is accepted while BL is set, and none is accepted when the controller's vector is all ones.
- R4: On any accepted trap, the saved status equals the old status, the saved PC equals the current PC and the saved R15 equals the current R15. The new status is the old status with bits 28, 29 and 30 set and every other bit kept.
- R5: When the trap is taken while the delay-slot flag is set, the saved PC is the current PC minus 2. `delayClear` pulses high for that one cycle.
- R6: Reset codes 0x000 and 0x020 set new status bits [7:4] to 0xF and jump to 0xA0000000.
- R7: Codes 0x040 and 0x060 jump to vector base + 0x400. Every other non-reset exception jumps to vector base + 0x100.
- R8: An accepted interrupt jumps to vector base + 0x600 and loads the interrupt-event output with the controller's vector. The exception-event output stays unchanged.
- R9: Code 0x160 saves the current PC plus 2.
- R10: An accepted exception loads the exception-event output with its effective code and leaves the interrupt-event output unchanged.
- R11: `taken` is high for exactly the one cycle that follows the edge that accepts a trap. All outputs update on that same edge.
- R12: An interrupt request seen while both sleeping and BL are set is held internally. It is taken once BL clears and the vector is valid, even if the request has since dropped. After that it is released.
- R13: After reset, every registered output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| excValid | input | 1 | An exception is pending |
| excCode | input | 12 | Code of the pending exception |
| irqReq | input | 1 | Hardware interrupt request |
| irqVector | input | 12 | Vector from the interrupt controller, all ones = none |
| srIn | input | 32 | Current status word |
| pcIn | input | 32 | Current program counter |
| r15In | input | 32 | Current register 15 |
| vbrIn | input | 32 | Vector base |
| inDelaySlot | input | 1 | The current instruction sits in a branch delay slot |
| sleeping | input | 1 | The core is in its sleep state |
| irqLevel | output | 4 | Acceptance level sent to the interrupt controller |
| taken | output | 1 | One-cycle pulse after a trap is accepted |
| delayClear | output | 1 | Pulse telling the core to clear its delay-slot flags |
| srOut | output | 32 | New status word |
| pcOut | output | 32 | Handler address |
| spcOut | output | 32 | Saved program counter |
| ssrOut | output | 32 | Saved status word |
| sgrOut | output | 32 | Saved register 15 |
| expevtOut | output | 12 | Exception event code |
| intevtOut | output | 12 | Interrupt event code |

## Verification
Each decision ends up in a register that the core reads in the cycle after the event, so a wrong internal choice is visible at the ports one cycle later:
- A wrong target selection shows up as a wrong `pcOut`.
- A wrong priority or a wrong blocking decision shows up as the wrong event output changing, or as a missing `taken`.
- A wrong rewind shows up as an off-by-two `spcOut`.

The held-interrupt flag is the only state that can stay hidden for long. It shows only when BL later clears: a stuck-clear flag means no `taken` at that point, and a stuck-set flag means a second, repeated `taken` on the following cycle.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int EVT_W    = 12;
  localparam int SR_BL    = 28;
  localparam int SR_RB    = 29;
  localparam int SR_MD    = 30;
  localparam int IMASK_LO = 4;
  localparam int IMASK_W  = 4;

  typedef enum logic [1:0] {
    TGT_RESET = 2'd0,
    TGT_TLB   = 2'd1,
    TGT_GEN   = 2'd2,
    TGT_IRQ   = 2'd3
  } tgt_e;

  typedef struct packed {
    logic             takeExc;
    logic             takeIrq;
    tgt_e             target;
    logic             rewind;
    logic             trapAdj;
    logic [EVT_W-1:0] code;
  } ctl_s;
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter logic [EVT_W-1:0] CODE_UNBLOCKABLE = 12'h1E0,
  parameter logic [EVT_W-1:0] CODE_RESET_A     = 12'h000,
  parameter logic [EVT_W-1:0] CODE_RESET_B     = 12'h020,
  parameter logic [EVT_W-1:0] CODE_TLB_RD      = 12'h040,
  parameter logic [EVT_W-1:0] CODE_TLB_WR      = 12'h060,
  parameter logic [EVT_W-1:0] CODE_TRAP        = 12'h160
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               excValid,
  input  logic [EVT_W-1:0]   excCode,
  input  logic               irqReq,
  input  logic [EVT_W-1:0]   irqVector,
  input  logic               srBl,
  input  logic [IMASK_W-1:0] srImask,
  input  logic               sleeping,
  input  logic               inDelaySlot,
  output logic [IMASK_W-1:0] irqLevel,
  output ctl_s               ctl
);
  localparam logic [EVT_W-1:0] NO_VECTOR = '1;

  logic             irqPend;
  logic             irqWant;
  logic [EVT_W-1:0] effCode;

  assign irqLevel = srImask;
  assign irqWant  = irqReq | irqPend;
  assign effCode  = (srBl && excCode != CODE_UNBLOCKABLE) ? CODE_RESET_A : excCode;

  always_comb begin
    ctl         = '0;
    ctl.takeExc = excValid;
    ctl.takeIrq = irqWant && !excValid && !srBl && (irqVector != NO_VECTOR);
    ctl.rewind  = inDelaySlot;
    ctl.code    = effCode;
    ctl.trapAdj = excValid && (effCode == CODE_TRAP);
    if (ctl.takeIrq)
      ctl.target = TGT_IRQ;
    else if (effCode == CODE_RESET_A || effCode == CODE_RESET_B)
      ctl.target = TGT_RESET;
    else if (effCode == CODE_TLB_RD || effCode == CODE_TLB_WR)
      ctl.target = TGT_TLB;
    else
      ctl.target = TGT_GEN;
  end

  // Request seen while asleep and blocked is kept until an interrupt is taken.
  always_ff @(posedge clk) begin
    if (rst)
      irqPend <= 1'b0;
    else if (ctl.takeIrq)
      irqPend <= 1'b0;
    else if (irqReq && srBl && sleeping)
      irqPend <= 1'b1;
  end

  AST_EXC_BEATS_IRQ: assert property (@(posedge clk) disable iff (rst)
    excValid |-> !ctl.takeIrq); // R1
  AST_BL_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    srBl |-> !ctl.takeIrq); // R3
  AST_IRQ_NEEDS_VECTOR: assert property (@(posedge clk) disable iff (rst)
    ctl.takeIrq |-> irqVector != NO_VECTOR); // R3
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
    !(ctl.takeExc && ctl.takeIrq)); // R1
endmodule

// File: rtl/trap_dpath.sv
module trap_dpath
  import trap_pkg::*;
#(
  parameter int                XLEN     = 32,
  parameter logic [XLEN-1:0]   RESET_PC = 32'hA000_0000,
  parameter logic [XLEN-1:0]   OFS_GEN  = 32'h0000_0100,
  parameter logic [XLEN-1:0]   OFS_TLB  = 32'h0000_0400,
  parameter logic [XLEN-1:0]   OFS_IRQ  = 32'h0000_0600
) (
  input  logic             clk,
  input  logic             rst,
  input  ctl_s             ctl,
  input  logic [XLEN-1:0]  srIn,
  input  logic [XLEN-1:0]  pcIn,
  input  logic [XLEN-1:0]  r15In,
  input  logic [XLEN-1:0]  vbrIn,
  input  logic [EVT_W-1:0] irqVector,
  output logic             taken,
  output logic             delayClear,
  output logic [XLEN-1:0]  srOut,
  output logic [XLEN-1:0]  pcOut,
  output logic [XLEN-1:0]  spcOut,
  output logic [XLEN-1:0]  ssrOut,
  output logic [XLEN-1:0]  sgrOut,
  output logic [EVT_W-1:0] expevtOut,
  output logic [EVT_W-1:0] intevtOut
);
  localparam logic [XLEN-1:0] STEP = XLEN'(2);

  logic            take;
  logic [XLEN-1:0] srNext;
  logic [XLEN-1:0] pcNext;
  logic [XLEN-1:0] spcNext;

  assign take = ctl.takeExc | ctl.takeIrq;

  always_comb begin
    srNext        = srIn;
    srNext[SR_BL] = 1'b1;
    srNext[SR_RB] = 1'b1;
    srNext[SR_MD] = 1'b1;
    if (ctl.target == TGT_RESET)
      srNext[IMASK_LO +: IMASK_W] = '1;
    spcNext = pcIn;
    if (ctl.rewind)  spcNext = spcNext - STEP;
    if (ctl.trapAdj) spcNext = spcNext + STEP;
    case (ctl.target)
      TGT_RESET: pcNext = RESET_PC;
      TGT_TLB:   pcNext = vbrIn + OFS_TLB;
      TGT_IRQ:   pcNext = vbrIn + OFS_IRQ;
      default:   pcNext = vbrIn + OFS_GEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      taken      <= 1'b0;
      delayClear <= 1'b0;
      srOut      <= '0;
      pcOut      <= '0;
      spcOut     <= '0;
      ssrOut     <= '0;
      sgrOut     <= '0;
      expevtOut  <= '0;
      intevtOut  <= '0;
    end else begin
      taken      <= take;
      delayClear <= take && ctl.rewind;
      if (take) begin
        srOut  <= srNext;
        pcOut  <= pcNext;
        spcOut <= spcNext;
        ssrOut <= srIn;
        sgrOut <= r15In;
      end
      if (ctl.takeExc) expevtOut <= ctl.code;
      if (ctl.takeIrq) intevtOut <= irqVector;
    end
  end

  AST_SAVED_SR: assert property (@(posedge clk) disable iff (rst)
    taken |-> ssrOut == $past(srIn)); // R4
  AST_BLOCK_FLAGS: assert property (@(posedge clk) disable iff (rst)
    taken |-> (srOut[SR_BL] && srOut[SR_RB] && srOut[SR_MD])); // R4
  AST_CLEAR_WITH_TAKEN: assert property (@(posedge clk) disable iff (rst)
    delayClear |-> taken); // R5
  AST_EVT_STABLE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !take |=> ($stable(expevtOut) && $stable(intevtOut))); // R10
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             excValid,
  input  logic [11:0]      excCode,
  input  logic             irqReq,
  input  logic [11:0]      irqVector,
  input  logic [31:0]      srIn,
  input  logic [31:0]      pcIn,
  input  logic [31:0]      r15In,
  input  logic [31:0]      vbrIn,
  input  logic             inDelaySlot,
  input  logic             sleeping,
  output logic [3:0]       irqLevel,
  output logic             taken,
  output logic             delayClear,
  output logic [31:0]      srOut,
  output logic [31:0]      pcOut,
  output logic [31:0]      spcOut,
  output logic [31:0]      ssrOut,
  output logic [31:0]      sgrOut,
  output logic [11:0]      expevtOut,
  output logic [11:0]      intevtOut
);
  ctl_s ctl;

  trap_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .excValid(excValid), .excCode(excCode),
    .irqReq(irqReq), .irqVector(irqVector),
    .srBl(srIn[SR_BL]), .srImask(srIn[IMASK_LO +: IMASK_W]),
    .sleeping(sleeping), .inDelaySlot(inDelaySlot),
    .irqLevel(irqLevel), .ctl(ctl)
  );

  trap_dpath #(.XLEN(XLEN)) u_dpath (
    .clk(clk), .rst(rst), .ctl(ctl),
    .srIn(srIn), .pcIn(pcIn), .r15In(r15In), .vbrIn(vbrIn),
    .irqVector(irqVector),
    .taken(taken), .delayClear(delayClear),
    .srOut(srOut), .pcOut(pcOut), .spcOut(spcOut),
    .ssrOut(ssrOut), .sgrOut(sgrOut),
    .expevtOut(expevtOut), .intevtOut(intevtOut)
  );
endmodule

// File: tb/trap_entry_seq_tb.sv
`timescale 1ns/1ps
module trap_entry_seq_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        excValid, irqReq, inDelaySlot, sleeping;
  logic [11:0] excCode, irqVector;
  logic [31:0] srIn, pcIn, r15In, vbrIn;
  logic [3:0]  irqLevel;
  logic        taken, delayClear;
  logic [31:0] srOut, pcOut, spcOut, ssrOut, sgrOut;
  logic [11:0] expevtOut, intevtOut;

  int nChecks = 0;
  int nFails  = 0;

  localparam logic [31:0] VBR = 32'h8C00_0000;
  localparam logic [31:0] PC  = 32'h8C00_1000;
  localparam logic [31:0] R15 = 32'h0000_1234;

  always #2 clk = ~clk;

  trap_entry_seq u_dut (
    .clk(clk), .rst(rst), .excValid(excValid), .excCode(excCode),
    .irqReq(irqReq), .irqVector(irqVector), .srIn(srIn), .pcIn(pcIn),
    .r15In(r15In), .vbrIn(vbrIn), .inDelaySlot(inDelaySlot),
    .sleeping(sleeping), .irqLevel(irqLevel), .taken(taken),
    .delayClear(delayClear), .srOut(srOut), .pcOut(pcOut),
    .spcOut(spcOut), .ssrOut(ssrOut), .sgrOut(sgrOut),
    .expevtOut(expevtOut), .intevtOut(intevtOut)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    excValid = 0; excCode = 0; irqReq = 0; irqVector = 12'hFFF;
    inDelaySlot = 0; sleeping = 0;
    srIn = 32'h0000_0000; pcIn = PC; r15In = R15; vbrIn = VBR;
  endtask

  // Present an exception for one cycle; results are valid at the next negedge.
  task automatic fireExc(input logic [11:0] code, input logic [31:0] sr, input logic ds);
    idle(); excValid = 1; excCode = code; srIn = sr; inDelaySlot = ds;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    chk("R13", "taken", {31'b0, taken}, 0);
    chk("R13", "pcOut", pcOut, 0);
    chk("R13", "srOut", srOut, 0);
    chk("R13", "expevt", {20'b0, expevtOut}, 0);
  endtask

  task automatic t_general();
    fireExc(12'h0E0, 32'h0000_00F0, 0);
    chk("R11", "taken", {31'b0, taken}, 1);
    chk("R4", "srOut", srOut, 32'h7000_00F0);
    chk("R4", "ssrOut", ssrOut, 32'h0000_00F0);
    chk("R4", "spcOut", spcOut, PC);
    chk("R4", "sgrOut", sgrOut, R15);
    chk("R7", "pcOut", pcOut, VBR + 32'h100);
    chk("R10", "expevt", {20'b0, expevtOut}, 32'h0E0);
    chk("R5", "delayClear", {31'b0, delayClear}, 0);
    @(negedge clk);
    chk("R11", "taken drop", {31'b0, taken}, 0);
  endtask

  task automatic t_tlb();
    fireExc(12'h040, 0, 0);
    chk("R7", "tlb rd pc", pcOut, VBR + 32'h400);
    fireExc(12'h060, 0, 0);
    chk("R7", "tlb wr pc", pcOut, VBR + 32'h400);
    chk("R10", "expevt", {20'b0, expevtOut}, 32'h060);
  endtask

  task automatic t_resetCode();
    fireExc(12'h020, 32'h0000_0000, 0);
    chk("R6", "pcOut", pcOut, 32'hA000_0000);
    chk("R6", "srOut", srOut, 32'h7000_00F0);
  endtask

  task automatic t_delay();
    fireExc(12'h180, 0, 1);
    chk("R5", "spcOut", spcOut, PC - 2);
    chk("R5", "delayClear", {31'b0, delayClear}, 1);
    @(negedge clk);
    chk("R5", "delayClear drop", {31'b0, delayClear}, 0);
  endtask

  task automatic t_trap();
    fireExc(12'h160, 0, 0);
    chk("R9", "spcOut", spcOut, PC + 2);
    chk("R9", "pcOut", pcOut, VBR + 32'h100);
  endtask

  task automatic t_irq();
    logic [11:0] prevExp;
    prevExp = expevtOut;
    idle(); srIn = 32'h0000_0030; irqReq = 1; irqVector = 12'h320;
    #1 chk("R3", "irqLevel", {28'b0, irqLevel}, 32'h3);
    @(negedge clk);
    idle();
    chk("R8", "taken", {31'b0, taken}, 1);
    chk("R8", "pcOut", pcOut, VBR + 32'h600);
    chk("R8", "intevt", {20'b0, intevtOut}, 32'h320);
    chk("R8", "expevt kept", {20'b0, expevtOut}, {20'b0, prevExp});
  endtask

  task automatic t_prio();
    idle(); excValid = 1; excCode = 12'h0E0; irqReq = 1; irqVector = 12'h340;
    @(negedge clk);
    idle();
    chk("R1", "intevt kept", {20'b0, intevtOut}, 32'h320);
    chk("R1", "pcOut", pcOut, VBR + 32'h100);
    chk("R1", "expevt", {20'b0, expevtOut}, 32'h0E0);
  endtask

  task automatic t_blocked();
    fireExc(12'h0E0, 32'h1000_0000, 0);
    chk("R2", "expevt", {20'b0, expevtOut}, 32'h000);
    chk("R2", "pcOut", pcOut, 32'hA000_0000);
    fireExc(12'h1E0, 32'h1000_0000, 0);
    chk("R2", "expevt keep", {20'b0, expevtOut}, 32'h1E0);
    chk("R2", "pcOut", pcOut, VBR + 32'h100);
    idle(); srIn = 32'h1000_0000; irqReq = 1; irqVector = 12'h500;
    @(negedge clk);
    idle();
    chk("R3", "BL irq taken", {31'b0, taken}, 0);
    chk("R3", "BL intevt", {20'b0, intevtOut}, 32'h320);
    idle(); irqReq = 1; irqVector = 12'hFFF;
    @(negedge clk);
    idle();
    chk("R3", "no vector taken", {31'b0, taken}, 0);
  endtask

  task automatic t_pend();
    idle(); srIn = 32'h1000_0000; sleeping = 1; irqReq = 1; irqVector = 12'h500;
    @(negedge clk);
    idle(); srIn = 32'h1000_0000; irqVector = 12'h500;
    chk("R12", "held not taken", {31'b0, taken}, 0);
    @(negedge clk);
    idle(); irqVector = 12'h500;
    chk("R12", "still blocked", {31'b0, taken}, 0);
    @(negedge clk);
    chk("R12", "taken after BL clear", {31'b0, taken}, 1);
    chk("R12", "intevt", {20'b0, intevtOut}, 32'h500);
    chk("R12", "pcOut", pcOut, VBR + 32'h600);
    @(negedge clk);
    idle();
    chk("R12", "released", {31'b0, taken}, 0);
  endtask

  initial begin
    #(200000 * 4);
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_general();
    t_tlb();
    t_resetCode();
    t_delay();
    t_trap();
    t_irq();
    t_prio();
    t_blocked();
    t_pend();
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule